// File: doc/BRIEF.md
# Two-Level Instruction Escape Dispatcher

This block sits beside a multi-context emulation pipeline and decides where each context's next instruction is executed. Each cycle the pipeline may present one decoded instruction class together with the number of the context it belongs to. Natively supported classes stay in hardware. Every other class pulls the context out of hardware and hands it to one of two escape levels. The near level is a software instruction-set emulator that covers the whole instruction set and answers within roughly a thousand cycles. The far level is the full-system host, which is the only place where I/O can run and which takes on the order of a million cycles.

Every context carries a 2-bit mode, and only a context in hardware mode may issue. Each level keeps a first-in first-out queue of waiting context numbers. It presents at most one request at a time, holds that request until the completion acknowledge returns with the same context number, and then returns the context to hardware. A wrapping event counter per level lets a bench or a performance model work out the effective cycles per instruction.

Each level runs a two-state machine. In `LVL_IDLE` no request is shown. The transition *dispatch* (`LVL_IDLE` to `LVL_WAIT`) pops the oldest queued context into the request. In `LVL_WAIT` the request is held. The transition *complete* (`LVL_WAIT` to `LVL_IDLE`) happens when a matching acknowledge arrives. Both levels are reset into `LVL_IDLE`.

Top module: `xplant_dispatch`

## Requirements
- R1: After reset every context is in mode 2'b00 (hardware) with its ready bit high, neither level shows a request, and both event counters are zero.
- R2: An accepted issue of class 0 (natively supported) leaves the context in mode 2'b00, raises no request and changes no counter.
- R3: An accepted issue of class 1 (unimplemented), 2 (translation miss), 3 (block memory), 5, 6 or 7 puts the context in mode 2'b01 (near emulator) from the next cycle on, queues it at the near level, and adds one to `near_events`.
- R4: An accepted issue of class 4 (I/O) puts the context in mode 2'b10 (full host) from the next cycle on, queues it at the host level, and adds one to `host_events`.
- R5: An issue for a context whose mode is not 2'b00 is ignored: its mode and both counters stay unchanged.
- R6: `ctx_ready[i]` is high exactly when context i is in mode 2'b00. Bits 2i+1:2i of `ctx_mode_flat` hold the mode of context i.
- R7: A level shows at most one request at a time. The request appears one cycle after the level, being idle, finds its queue non-empty. Its context number stays stable until the request is acknowledged, and that context is in the level's mode while the request is shown.
- R8: Each level serves its queued contexts in the order in which they escalated, and its queue never overflows.
- R9: An acknowledge whose context number equals the shown request drops the request and returns that context to mode 2'b00 on the next cycle. An acknowledge at any other time, or carrying another context number, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | A decoded instruction is presented |
| issue_ctx | input | CTX_W | Context of the presented instruction |
| issue_class | input | 3 | Instruction class code (see R2 to R4) |
| ctx_ready | output | NUM_CTX | Per-context hardware-mode flag |
| ctx_mode_flat | output | 2*NUM_CTX | Packed per-context 2-bit modes |
| near_req_valid | output | 1 | Near-emulator request shown |
| near_req_ctx | output | CTX_W | Context of the near request |
| near_ack_valid | input | 1 | Near-emulator completion |
| near_ack_ctx | input | CTX_W | Context the near completion refers to |
| host_req_valid | output | 1 | Full-host request shown |
| host_req_ctx | output | CTX_W | Context of the host request |
| host_ack_valid | input | 1 | Full-host completion |
| host_ack_ctx | input | CTX_W | Context the host completion refers to |
| near_events | output | COUNT_W | Wrapping count of near escalations |
| host_events | output | COUNT_W | Wrapping count of host escalations |

## Verification
The hardest situation to reach is a long queue at one level while that level's single request is held and stray acknowledges for other contexts arrive. In that situation, ordering, the stability of the held request and the ignoring of wrong acknowledges all matter at once. The stimulus reaches it in two steps. A directed sequence first escalates five contexts with no acknowledges, then sends a wrong-context acknowledge. A random phase follows in which acknowledges are rare, often carry a random context, and fall while new escalations and issues to blocked contexts keep arriving. A final drain phase returns every context to hardware.

// File: rtl/xplant_pkg.sv
package xplant_pkg;

    typedef enum logic [1:0] {
        MODE_HW   = 2'b00,
        MODE_NEAR = 2'b01,
        MODE_HOST = 2'b10
    } ctx_mode_e;

    typedef enum logic {
        LVL_IDLE = 1'b0,
        LVL_WAIT = 1'b1
    } lvl_state_e;

    localparam int NUM_LEVELS = 2;
    localparam int CLASS_W    = 3;
    localparam logic [CLASS_W-1:0] CLASS_NATIVE = 3'd0;
    localparam logic [CLASS_W-1:0] CLASS_IO     = 3'd4;

endpackage

// File: rtl/xplant_classify.sv
module xplant_classify
    import xplant_pkg::*;
(
    input  logic [CLASS_W-1:0] cls,
    output ctx_mode_e          route
);
    always_comb begin
        unique case (cls)
            CLASS_NATIVE: route = MODE_HW;
            CLASS_IO:     route = MODE_HOST;
            default:      route = MODE_NEAR;
        endcase
    end
endmodule

// File: rtl/xplant_ctxfifo.sv
module xplant_ctxfifo #(
    parameter int DEPTH = 8,
    parameter int W     = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] fill;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (int'(p) == DEPTH - 1) return '0;
        return p + 1'b1;
    endfunction

    assign empty    = (fill == '0);
    assign full     = (int'(fill) == DEPTH);
    assign pop_data = store[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push && !full) wr_ptr <= bump(wr_ptr);
            if (pop && !empty) rd_ptr <= bump(rd_ptr);
            unique case ({push && !full, pop && !empty})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) store[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/xplant_level.sv
module xplant_level
    import xplant_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int COUNT_W = 16,
    localparam int CTX_W  = $clog2(NUM_CTX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               esc_valid,
    input  logic [CTX_W-1:0]   esc_ctx,
    input  logic               ack_valid,
    input  logic [CTX_W-1:0]   ack_ctx,
    output logic               req_valid,
    output logic [CTX_W-1:0]   req_ctx,
    output logic               done_valid,
    output logic [CTX_W-1:0]   done_ctx,
    output logic [COUNT_W-1:0] event_count,
    output logic               q_push,
    output logic               q_full
);
    lvl_state_e       state_q;
    lvl_state_e       state_d;
    logic [CTX_W-1:0] held_ctx_q;
    logic             q_empty;
    logic             q_pop;
    logic [CTX_W-1:0] q_head;
    logic             ack_hit;

    xplant_ctxfifo #(.DEPTH(NUM_CTX), .W(CTX_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (esc_valid),
        .push_data (esc_ctx),
        .pop       (q_pop),
        .pop_data  (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    assign q_push  = esc_valid;
    assign ack_hit = ack_valid && (ack_ctx == held_ctx_q);

    // next state: dispatch and complete transitions
    always_comb begin
        state_d = state_q;
        q_pop   = 1'b0;
        unique case (state_q)
            LVL_IDLE: begin
                if (!q_empty) begin
                    state_d = LVL_WAIT;
                    q_pop   = 1'b1;
                end
            end
            LVL_WAIT: begin
                if (ack_hit) state_d = LVL_IDLE;
            end
            default: state_d = LVL_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= LVL_IDLE;
            held_ctx_q <= '0;
        end else begin
            state_q <= state_d;
            if (q_pop) held_ctx_q <= q_head;
        end
    end

    // outputs
    always_comb begin
        req_valid  = 1'b0;
        done_valid = 1'b0;
        unique case (state_q)
            LVL_IDLE: req_valid = 1'b0;
            LVL_WAIT: begin
                req_valid  = 1'b1;
                done_valid = ack_hit;
            end
            default: req_valid = 1'b0;
        endcase
        req_ctx  = held_ctx_q;
        done_ctx = held_ctx_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         event_count <= '0;
        else if (esc_valid) event_count <= event_count + 1'b1;
    end
endmodule

// File: rtl/xplant_dispatch.sv
module xplant_dispatch
    import xplant_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int COUNT_W = 16,
    localparam int CTX_W  = $clog2(NUM_CTX)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   issue_valid,
    input  logic [CTX_W-1:0]       issue_ctx,
    input  logic [2:0]             issue_class,
    output logic [NUM_CTX-1:0]     ctx_ready,
    output logic [2*NUM_CTX-1:0]   ctx_mode_flat,
    output logic                   near_req_valid,
    output logic [CTX_W-1:0]       near_req_ctx,
    input  logic                   near_ack_valid,
    input  logic [CTX_W-1:0]       near_ack_ctx,
    output logic                   host_req_valid,
    output logic [CTX_W-1:0]       host_req_ctx,
    input  logic                   host_ack_valid,
    input  logic [CTX_W-1:0]       host_ack_ctx,
    output logic [COUNT_W-1:0]     near_events,
    output logic [COUNT_W-1:0]     host_events
);
    ctx_mode_e        mode_q [NUM_CTX];
    ctx_mode_e        route;
    ctx_mode_e        sel_mode;
    logic             accept;
    logic [NUM_CTX-1:0] release_hit;

    logic [NUM_LEVELS-1:0] lvl_esc;
    logic [NUM_LEVELS-1:0] lvl_ack_valid;
    logic [CTX_W-1:0]      lvl_ack_ctx   [NUM_LEVELS];
    logic [NUM_LEVELS-1:0] lvl_req_valid;
    logic [CTX_W-1:0]      lvl_req_ctx   [NUM_LEVELS];
    logic [NUM_LEVELS-1:0] lvl_done_valid;
    logic [CTX_W-1:0]      lvl_done_ctx  [NUM_LEVELS];
    logic [COUNT_W-1:0]    lvl_count     [NUM_LEVELS];
    logic [NUM_LEVELS-1:0] lvl_q_push;
    logic [NUM_LEVELS-1:0] lvl_q_full;

    xplant_classify u_classify (
        .cls   (issue_class),
        .route (route)
    );

    // mode of the issuing context; out-of-range numbers look blocked
    always_comb begin
        sel_mode = MODE_HOST;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (int'(issue_ctx) == i) sel_mode = mode_q[i];
        end
    end

    assign accept = issue_valid && (sel_mode == MODE_HW) && (route != MODE_HW);

    assign lvl_ack_valid[0] = near_ack_valid;
    assign lvl_ack_ctx[0]   = near_ack_ctx;
    assign lvl_ack_valid[1] = host_ack_valid;
    assign lvl_ack_ctx[1]   = host_ack_ctx;

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_level
        localparam ctx_mode_e LVL_MODE = (l == 0) ? MODE_NEAR : MODE_HOST;

        assign lvl_esc[l] = accept && (route == LVL_MODE);

        xplant_level #(.NUM_CTX(NUM_CTX), .COUNT_W(COUNT_W)) u_level (
            .clk         (clk),
            .rst_n       (rst_n),
            .esc_valid   (lvl_esc[l]),
            .esc_ctx     (issue_ctx),
            .ack_valid   (lvl_ack_valid[l]),
            .ack_ctx     (lvl_ack_ctx[l]),
            .req_valid   (lvl_req_valid[l]),
            .req_ctx     (lvl_req_ctx[l]),
            .done_valid  (lvl_done_valid[l]),
            .done_ctx    (lvl_done_ctx[l]),
            .event_count (lvl_count[l]),
            .q_push      (lvl_q_push[l]),
            .q_full      (lvl_q_full[l])
        );
    end

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
        always_comb begin
            release_hit[i] = 1'b0;
            for (int l = 0; l < NUM_LEVELS; l++) begin
                if (lvl_done_valid[l] && int'(lvl_done_ctx[l]) == i) release_hit[i] = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   mode_q[i] <= MODE_HW;
            else if (release_hit[i])                      mode_q[i] <= MODE_HW;
            else if (accept && int'(issue_ctx) == i)      mode_q[i] <= route;
        end

        assign ctx_ready[i]           = (mode_q[i] == MODE_HW);
        assign ctx_mode_flat[2*i +: 2] = mode_q[i];
    end

    assign near_req_valid = lvl_req_valid[0];
    assign near_req_ctx   = lvl_req_ctx[0];
    assign host_req_valid = lvl_req_valid[1];
    assign host_req_ctx   = lvl_req_ctx[1];
    assign near_events    = lvl_count[0];
    assign host_events    = lvl_count[1];
endmodule

// File: rtl/xplant_dispatch_chk.sv
module xplant_dispatch_chk #(
    parameter int NUM_CTX = 8,
    parameter int COUNT_W = 16,
    localparam int CTX_W  = $clog2(NUM_CTX)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 issue_valid,
    input logic [CTX_W-1:0]     issue_ctx,
    input logic [NUM_CTX-1:0]   ctx_ready,
    input logic [2*NUM_CTX-1:0] ctx_mode_flat,
    input logic                 near_req_valid,
    input logic [CTX_W-1:0]     near_req_ctx,
    input logic                 near_ack_valid,
    input logic [CTX_W-1:0]     near_ack_ctx,
    input logic                 host_req_valid,
    input logic [CTX_W-1:0]     host_req_ctx,
    input logic                 host_ack_valid,
    input logic [CTX_W-1:0]     host_ack_ctx,
    input logic [COUNT_W-1:0]   near_events,
    input logic [COUNT_W-1:0]   host_events,
    input logic [1:0]           lvl_q_push,
    input logic [1:0]           lvl_q_full
);
    assert_near_req_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        near_req_valid |-> ctx_mode_flat[2*int'(near_req_ctx) +: 2] == 2'b01);

    assert_host_req_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_req_valid |-> ctx_mode_flat[2*int'(host_req_ctx) +: 2] == 2'b10);

    assert_near_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        near_req_valid && !(near_ack_valid && near_ack_ctx == near_req_ctx)
        |=> near_req_valid && $stable(near_req_ctx));

    assert_host_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_req_valid && !(host_ack_valid && host_ack_ctx == host_req_ctx)
        |=> host_req_valid && $stable(host_req_ctx));

    assert_near_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        near_req_valid && near_ack_valid && near_ack_ctx == near_req_ctx
        |=> ctx_mode_flat[2*int'($past(near_req_ctx)) +: 2] == 2'b00);

    assert_host_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_req_valid && host_ack_valid && host_ack_ctx == host_req_ctx
        |=> ctx_ready[$past(host_req_ctx)]);

    assert_blocked_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !ctx_ready[issue_ctx]
        |=> $stable(near_events) && $stable(host_events));

    assert_near_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        near_events != $past(near_events)
        |-> near_events == COUNT_W'($past(near_events) + 1'b1));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q_push & lvl_q_full) == 2'b00);
endmodule

bind xplant_dispatch xplant_dispatch_chk #(.NUM_CTX(NUM_CTX), .COUNT_W(COUNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .issue_valid    (issue_valid),
    .issue_ctx      (issue_ctx),
    .ctx_ready      (ctx_ready),
    .ctx_mode_flat  (ctx_mode_flat),
    .near_req_valid (near_req_valid),
    .near_req_ctx   (near_req_ctx),
    .near_ack_valid (near_ack_valid),
    .near_ack_ctx   (near_ack_ctx),
    .host_req_valid (host_req_valid),
    .host_req_ctx   (host_req_ctx),
    .host_ack_valid (host_ack_valid),
    .host_ack_ctx   (host_ack_ctx),
    .near_events    (near_events),
    .host_events    (host_events),
    .lvl_q_push     (lvl_q_push),
    .lvl_q_full     (lvl_q_full)
);

// File: tb/test_xplant_dispatch.sv
module test_xplant_dispatch;
    localparam int N  = 8;
    localparam int CW = 16;
    localparam int XW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_valid = 1'b0;
    logic [XW-1:0] issue_ctx = '0;
    logic [2:0] issue_class = '0;
    logic near_ack_valid = 1'b0, host_ack_valid = 1'b0;
    logic [XW-1:0] near_ack_ctx = '0, host_ack_ctx = '0;
    logic [N-1:0] ctx_ready;
    logic [2*N-1:0] ctx_mode_flat;
    logic near_req_valid, host_req_valid;
    logic [XW-1:0] near_req_ctx, host_req_ctx;
    logic [CW-1:0] near_events, host_events;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int mmode [N];
    int nq[$];
    int hq[$];
    bit mbusy [2];
    int mcur [2];
    int mcnt [2];

    always #2 clk = ~clk;

    xplant_dispatch #(.NUM_CTX(N), .COUNT_W(CW)) i_xplant_dispatch (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_ctx(issue_ctx), .issue_class(issue_class),
        .ctx_ready(ctx_ready), .ctx_mode_flat(ctx_mode_flat),
        .near_req_valid(near_req_valid), .near_req_ctx(near_req_ctx),
        .near_ack_valid(near_ack_valid), .near_ack_ctx(near_ack_ctx),
        .host_req_valid(host_req_valid), .host_req_ctx(host_req_ctx),
        .host_ack_valid(host_ack_valid), .host_ack_ctx(host_ack_ctx),
        .near_events(near_events), .host_events(host_events)
    );

    function automatic int route_of(input int cls);
        if (cls == 0) return 0;
        if (cls == 4) return 2;
        return 1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_step(input bit iv, input int ictx, input int icls,
                              input bit nav, input int nactx, input bit hav, input int hactx);
        int rt;
        bit acc;
        rt  = route_of(icls);
        acc = iv && (mmode[ictx] == 0) && (rt != 0);
        if (mbusy[0]) begin
            if (nav && nactx == mcur[0]) begin mbusy[0] = 0; mmode[mcur[0]] = 0; end
        end else if (nq.size() > 0) begin
            mcur[0] = nq.pop_front(); mbusy[0] = 1;
        end
        if (mbusy[1]) begin
            if (hav && hactx == mcur[1]) begin mbusy[1] = 0; mmode[mcur[1]] = 0; end
        end else if (hq.size() > 0) begin
            mcur[1] = hq.pop_front(); mbusy[1] = 1;
        end
        if (acc) begin
            mmode[ictx] = rt;
            if (rt == 1) begin nq.push_back(ictx); mcnt[0]++; end
            else begin hq.push_back(ictx); mcnt[1]++; end
        end
    endtask

    task automatic check_all();
        logic [2*N-1:0] em;
        logic [N-1:0] er;
        for (int i = 0; i < N; i++) begin
            em[2*i +: 2] = 2'(mmode[i]);
            er[i] = (mmode[i] == 0);
        end
        check(ctx_mode_flat == em, "R3/R4/R9", "modes", ctx_mode_flat, em);
        check(ctx_ready == er, "R6", "ready", ctx_ready, er);
        check(near_req_valid == mbusy[0], "R7", "near req valid", near_req_valid, mbusy[0]);
        check(host_req_valid == mbusy[1], "R7", "host req valid", host_req_valid, mbusy[1]);
        if (mbusy[0]) check(int'(near_req_ctx) == mcur[0], "R8", "near req ctx", near_req_ctx, mcur[0]);
        if (mbusy[1]) check(int'(host_req_ctx) == mcur[1], "R8", "host req ctx", host_req_ctx, mcur[1]);
        check(near_events == CW'(mcnt[0]), "R3", "near count", near_events, CW'(mcnt[0]));
        check(host_events == CW'(mcnt[1]), "R4", "host count", host_events, CW'(mcnt[1]));
    endtask

    task automatic step(input bit iv, input int ictx, input int icls,
                        input bit nav, input int nactx, input bit hav, input int hactx);
        issue_valid    = iv;
        issue_ctx      = XW'(ictx);
        issue_class    = 3'(icls);
        near_ack_valid = nav;
        near_ack_ctx   = XW'(nactx);
        host_ack_valid = hav;
        host_ack_ctx   = XW'(hactx);
        model_step(iv, ictx, icls, nav, nactx, hav, hactx);
        @(negedge clk);
        check_all();
    endtask

    task automatic rand_step(input int ack_mod);
        bit nav, hav;
        int na, ha;
        nav = ($urandom % ack_mod) == 0;
        hav = ($urandom % ack_mod) == 0;
        na  = ($urandom % 2) ? mcur[0] : int'($urandom % N);
        ha  = ($urandom % 2) ? mcur[1] : int'($urandom % N);
        step(($urandom % 3) != 0, int'($urandom % N), int'($urandom % 8), nav, na, hav, ha);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) mmode[i] = 0;
        mbusy[0] = 0; mbusy[1] = 0; mcur[0] = 0; mcur[1] = 0; mcnt[0] = 0; mcnt[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ctx_ready == '1 && ctx_mode_flat == '0, "R1", "reset modes", ctx_mode_flat, 0);
        check(!near_req_valid && !host_req_valid && near_events == 0 && host_events == 0,
              "R1", "reset requests/counters", {near_req_valid, host_req_valid}, 0);

        // R2 native class keeps hardware mode
        step(1, 0, 0, 0, 0, 0, 0);
        check(ctx_mode_flat[1:0] == 2'b00 && near_events == 0 && host_events == 0 && !near_req_valid,
              "R2", "native stays", ctx_mode_flat[1:0], 0);
        // R4 I/O, R3 other escape classes
        step(1, 1, 4, 0, 0, 0, 0);
        check(ctx_mode_flat[3:2] == 2'b10, "R4", "io mode", ctx_mode_flat[3:2], 2);
        step(1, 2, 1, 0, 0, 0, 0);
        step(1, 3, 2, 0, 0, 0, 0);
        step(1, 4, 3, 0, 0, 0, 0);
        step(1, 5, 7, 0, 0, 0, 0);
        check(ctx_mode_flat[5:4] == 2'b01 && ctx_mode_flat[11:10] == 2'b01, "R3", "near modes",
              ctx_mode_flat, 16'h0);
        // R5 issue to blocked context ignored
        step(1, 1, 1, 0, 0, 0, 0);
        check(ctx_mode_flat[3:2] == 2'b10 && near_events == 4 && host_events == 1,
              "R5", "blocked issue", {near_events, host_events}, {16'd4, 16'd1});
        // R8 oldest near context served first; R9 wrong ack ignored
        step(0, 0, 0, 0, 0, 0, 0);
        check(near_req_valid && near_req_ctx == 2, "R8", "first served", near_req_ctx, 2);
        step(0, 0, 0, 1, 3, 0, 0);
        check(near_req_valid && near_req_ctx == 2 && ctx_mode_flat[7:6] == 2'b01,
              "R9", "wrong ack ignored", near_req_ctx, 2);
        step(0, 0, 0, 1, 2, 1, 1);
        check(ctx_ready[2] && ctx_ready[1], "R9", "ack releases", ctx_ready, 0);

        // random phases: rare acks then frequent acks
        for (int k = 0; k < 1500; k++) rand_step(16);
        for (int k = 0; k < 1500; k++) rand_step(3);
        // drain
        for (int k = 0; k < 200; k++) step(0, 0, 0, 1, mcur[0], 1, mcur[1]);
        check(ctx_ready == '1, "R9", "drained", ctx_ready, {N{1'b1}});

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule